// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry input. The operands are split into four 4-bit slices. Each slice forms its own internal carries by fully expanded lookahead from per-bit generate and propagate terms, and it reports a slice propagate and a slice generate. A second lookahead stage takes those slice terms and the carry input and produces the carry into every slice and the final carry-out in parallel, so the critical path does not grow with each slice.

A build-time parameter picks the carry scheme between slices. The default uses the second-level lookahead. The alternative links each slice's carry-out to the next slice's carry-in, so carries ripple from slice to slice. The two builds give identical results and differ only in carry delay.

The block also brings out the propagate and generate terms for the whole 16-bit word, so that a further lookahead stage can place four of these adders side by side. All outputs are registered once, and an active-low reset clears them.

Top module: `cla16_adder`

## Requirements
- R1: While rstN is low, and at the first clock edge that follows, sumOut, carryOut, blockProp and blockGen all read 0, whatever the operands are.
- R2: One clock edge after opA, opB and carryIn are sampled, {carryOut, sumOut} equals opA + opB + carryIn as a 17-bit unsigned sum.
- R3: blockProp is 1 exactly when every bit position has at least one operand bit set. Per-bit propagate is a OR b, and blockProp is the AND of these over all 16 bits.
- R4: blockGen is 1 exactly when opA + opB, with the carry input taken as 0, carries out of bit 15. Per-bit generate is a AND b.
- R5: Whenever blockGen is 1, carryOut is 1 in the same cycle.
- R6: When blockProp is 1 and blockGen is 0, carryOut equals the carryIn sampled at the same edge.
- R7: The lookahead build (carryMode = CARRY_LOOKAHEAD) and the slice-ripple build (carryMode = CARRY_RIPPLE) give the same sumOut, carryOut, blockProp and blockGen for the same inputs. The carry each slice produces internally agrees with the carry the second-level stage forms for the next slice.
- R8: A carry entering at bit 0 passes through all four slices: 0xFFFF + 0x0000 + 1 gives sumOut 0x0000 and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 16 | Registered sum |
| carryOut | output | 1 | Registered carry out of bit 15 |
| blockProp | output | 1 | Registered propagate term for the whole word |
| blockGen | output | 1 | Registered generate term for the whole word |

## Verification
The adder is driven with zero operands, with carry chains that stop at a slice boundary, with a chain of all-propagate bits that a single carry-in runs through, with both operands all ones, and with complementary patterns that set blockProp while blockGen stays low. The complementary patterns, used with carryIn at 0 and at 1, separate the propagate term from the generate term. The full-length chain and the boundary-crossing cases check that the second-level stage hands each slice the right carry-in. Both carry builds are run side by side on every vector so that any mismatch between them is reported.

// File: rtl/cla_pkg.sv
package cla_pkg;
  typedef enum logic {
    CARRY_RIPPLE    = 1'b0,
    CARRY_LOOKAHEAD = 1'b1
  } carry_mode_e;

  localparam int unsigned DefGroupW    = 4;
  localparam int unsigned DefNumGroups = 4;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a,
  input  logic [GROUP_W-1:0] b,
  input  logic               cIn,
  output logic [GROUP_W-1:0] sum,
  output logic               grpProp,
  output logic               grpGen,
  output logic               cOut
);
  logic [GROUP_W-1:0] bitGen;
  logic [GROUP_W-1:0] bitProp;
  logic [GROUP_W:0]   carry;

  assign bitGen  = a & b;
  assign bitProp = a | b;

  // Each internal carry is a flat sum of products; no term depends on another carry.
  always_comb begin
    logic genAcc;
    logic prodTerm;
    logic inTerm;
    carry[0] = cIn;
    genAcc   = 1'b0;
    for (int j = 0; j < GROUP_W; j++) begin
      genAcc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        prodTerm = bitGen[k];
        for (int m = k + 1; m <= j; m++) prodTerm = prodTerm & bitProp[m];
        genAcc = genAcc | prodTerm;
      end
      inTerm = cIn;
      for (int m = 0; m <= j; m++) inTerm = inTerm & bitProp[m];
      carry[j+1] = genAcc | inTerm;
    end
    grpGen = genAcc;
  end

  assign grpProp = &bitProp;
  assign sum     = a ^ b ^ carry[GROUP_W-1:0];
  assign cOut    = carry[GROUP_W];
endmodule

// File: rtl/cla_carry_unit.sv
module cla_carry_unit #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS-1:0] grpProp,
  input  logic [NUM_GROUPS-1:0] grpGen,
  input  logic                  cIn,
  output logic [NUM_GROUPS:0]   carries,
  output logic                  blkProp,
  output logic                  blkGen
);
  // Second-level lookahead: carry into each group formed directly from group P/G.
  always_comb begin
    logic genAcc;
    logic prodTerm;
    logic inTerm;
    carries[0] = cIn;
    genAcc     = 1'b0;
    for (int j = 0; j < NUM_GROUPS; j++) begin
      genAcc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        prodTerm = grpGen[k];
        for (int m = k + 1; m <= j; m++) prodTerm = prodTerm & grpProp[m];
        genAcc = genAcc | prodTerm;
      end
      inTerm = cIn;
      for (int m = 0; m <= j; m++) inTerm = inTerm & grpProp[m];
      carries[j+1] = genAcc | inTerm;
    end
    blkGen = genAcc;
  end

  assign blkProp = &grpProp;
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int unsigned GROUP_W    = DefGroupW,
  parameter int unsigned NUM_GROUPS = DefNumGroups,
  parameter carry_mode_e carryMode  = CARRY_LOOKAHEAD
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [GROUP_W*NUM_GROUPS-1:0] opA,
  input  logic [GROUP_W*NUM_GROUPS-1:0] opB,
  input  logic                          carryIn,
  output logic [GROUP_W*NUM_GROUPS-1:0] sumOut,
  output logic                          carryOut,
  output logic                          blockProp,
  output logic                          blockGen
);
  localparam int unsigned Width = GROUP_W * NUM_GROUPS;

  logic [NUM_GROUPS-1:0] grpProp;
  logic [NUM_GROUPS-1:0] grpGen;
  logic [NUM_GROUPS-1:0] grpCout;
  logic [NUM_GROUPS-1:0] grpCin;
  logic [NUM_GROUPS:0]   laCarry;
  logic [Width-1:0]      sumNext;
  logic                  coutNext;
  logic                  blkProp;
  logic                  blkGen;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
    cla_group #(.GROUP_W(GROUP_W)) u_group (
      .a       (opA[g*GROUP_W +: GROUP_W]),
      .b       (opB[g*GROUP_W +: GROUP_W]),
      .cIn     (grpCin[g]),
      .sum     (sumNext[g*GROUP_W +: GROUP_W]),
      .grpProp (grpProp[g]),
      .grpGen  (grpGen[g]),
      .cOut    (grpCout[g])
    );

    // R7: carry a group forms internally must match the second-level carry into the next group
    assert_group_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
      grpCout[g] == laCarry[g+1]);
  end

  cla_carry_unit #(.NUM_GROUPS(NUM_GROUPS)) u_carry (
    .grpProp (grpProp),
    .grpGen  (grpGen),
    .cIn     (carryIn),
    .carries (laCarry),
    .blkProp (blkProp),
    .blkGen  (blkGen)
  );

  if (carryMode == CARRY_LOOKAHEAD) begin : gen_lookahead
    assign grpCin   = laCarry[NUM_GROUPS-1:0];
    assign coutNext = laCarry[NUM_GROUPS];
  end else begin : gen_ripple
    assign grpCin   = {grpCout[NUM_GROUPS-2:0], carryIn};
    assign coutNext = grpCout[NUM_GROUPS-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumOut    <= '0;
      carryOut  <= 1'b0;
      blockProp <= 1'b0;
      blockGen  <= 1'b0;
    end else begin
      sumOut    <= sumNext;
      carryOut  <= coutNext;
      blockProp <= blkProp;
      blockGen  <= blkGen;
    end
  end

  assert_sum_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> {carryOut, sumOut} ==
      ({1'b0, $past(opA)} + {1'b0, $past(opB)} + {{Width{1'b0}}, $past(carryIn)}));

  assert_reset_R1: assert property (@(posedge clk)
    !$past(rstN) |-> (sumOut == '0 && !carryOut && !blockProp && !blockGen));

  assert_gen_carry_R5: assert property (@(posedge clk) disable iff (!rstN)
    blockGen |-> carryOut);

  assert_prop_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && blockProp && !blockGen) |-> carryOut == $past(carryIn));

  assert_prop_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> blockProp == (&($past(opA) | $past(opB))));
endmodule

// File: tb/cla16_adder_bench.sv
module cla16_adder_bench;
  import cla_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sumL, sumR;
  logic        coutL, coutR, propL, propR, genL, genR;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cla16_adder #(.carryMode(CARRY_LOOKAHEAD)) u_cla16_adder (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumL), .carryOut(coutL), .blockProp(propL), .blockGen(genL));

  cla16_adder #(.carryMode(CARRY_RIPPLE)) u_cla16_adder_ripple (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .carryIn(carryIn),
    .sumOut(sumR), .carryOut(coutR), .blockProp(propR), .blockGen(genR));

  // {opA, opB, carryIn}
  localparam int NumVec = 10;
  localparam logic [32:0] Vecs [NumVec] = '{
    {16'h0000, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0},
    {16'h1234, 16'h4321, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1},
    {16'h0F0F, 16'hF0F0, 1'b1},
    {16'h0F0F, 16'hF0F0, 1'b0},
    {16'h8000, 16'h8000, 1'b0},
    {16'h00FF, 16'h0001, 1'b0},
    {16'h7FFF, 16'h0001, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1}
  };

  task automatic check(string req, logic [16:0] act, logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic applyAndCheck(logic [15:0] a, logic [15:0] b, logic ci);
    logic [16:0] expSum;
    logic        expP, expG;
    @(negedge clk);
    opA = a; opB = b; carryIn = ci;
    expSum = {1'b0, a} + {1'b0, b} + {16'b0, ci};
    expP   = &(a | b);
    expG   = ({1'b0, a} + {1'b0, b}) >> 16;
    @(negedge clk);
    check("R2 sum", {coutL, sumL}, expSum);
    check("R3 prop", {16'b0, propL}, {16'b0, expP});
    check("R4 gen", {16'b0, genL}, {16'b0, expG});
    check("R7 ripple match", {coutR, sumR}, {coutL, sumL});
    check("R7 ripple pg", {15'b0, propR, genR}, {15'b0, propL, genL});
    if (expG) check("R5 gen forces carry", {16'b0, coutL}, 17'd1);
    if (expP && !expG) check("R6 prop passes cin", {16'b0, coutL}, {16'b0, ci});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    opA = 16'hFFFF; opB = 16'hFFFF; carryIn = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset lookahead", {coutL, sumL}, 17'd0);
    check("R1 reset flags", {15'b0, propL, genL}, 17'd0);
    check("R1 reset ripple", {coutR, sumR}, 17'd0);
    rstN = 1'b1;

    for (int i = 0; i < NumVec; i++)
      applyAndCheck(Vecs[i][32:17], Vecs[i][16:1], Vecs[i][0]);

    // R8: carry-in travels through every group
    applyAndCheck(16'hFFFF, 16'h0000, 1'b1);
    check("R8 full chain", {coutL, sumL}, {1'b1, 16'h0000});

    // R1: reset applied mid-run clears outputs despite active operands
    @(negedge clk);
    opA = 16'hFFFF; opB = 16'h0001; carryIn = 1'b1; rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {coutL, sumL}, 17'd0);
    check("R1 mid-run flags", {15'b0, propL, genL}, 17'd0);
    rstN = 1'b1;
    applyAndCheck(16'h00F0, 16'h0010, 1'b0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule